// File: doc/BRIEF.md
# Removable Card Configuration Register Bank

This block holds the card-side configuration registers of a removable storage card. It sits behind a byte-wide register port with an address, a write strobe, a read strobe and write/read data. Below a configurable base address the port reads bytes from an external card-information ROM. Those reads return zero once the address is past the end of the ROM. At and above the base address, four byte registers are decoded at even offsets: option (+0), status (+2), pin replacement (+4) and socket/copy (+6).

The block also derives the host interrupt request. The inputs are the inner disk controller's interrupt line and two bits from the device-control register, which is held elsewhere: interrupt disable and soft reset. A write of the option register with its soft-reset bit set clears the whole bank. The same write sends a one-cycle reset pulse to the rest of the card. Read data is registered. The port has no back-pressure: every strobe is accepted in the cycle it is presented, so no valid/ready handshake is needed.

Top module: `pccfg_bank`

## Requirements
- R1: A read of an address below the base and below the ROM length returns `rom_data`, which is looked up at `rom_addr`; `rom_addr` mirrors `addr`.
- R2: A read of an address below the base but at or past the ROM length returns 0x00.
- R3: A write to offset +0 with bit 7 clear stores the written value ANDed with 0xCF, and a read of +0 returns that stored value.
- R4: A write to offset +0 with bit 7 set clears the option, status and pin registers, so the option register then reads 0x00 (memory-mapped mode). In the cycle after such a write, `card_rst` is high for exactly one cycle and `host_irq` is low.
- R5: A write to offset +2 keeps the stored bits under mask 0x82 and loads bits under mask 0x74 from the written value.
- R6: A status write whose bit 2 (power-down) differs from the stored bit 2 sets the card-ready bit 0x20 of the pin register. A status write with an equal bit 2 leaves the card-ready bit unchanged.
- R7: A read of +2 returns the stored status with bit 0x02 cleared while `ctl_irq_off` is high, and returns it unchanged otherwise.
- R8: A read of +4 returns the card-ready bit (0x20) ORed with 0x0C. A write to +4 never clears the card-ready bit and only loads its bit 0x02.
- R9: Offset +6 and every other undefined offset at or above the base read 0x00. Writes to those offsets, and writes below the base, change no register.
- R10: Status bit 0x02 holds the inverse of `ide_irq` as sampled at the previous clock edge.
- R11: `host_irq` is registered. It is high in the cycle after an edge where status bit 0x02 becomes clear, `ctl_irq_off` and `ctl_soft_rst` are both low, and no soft-reset write is taking place. Otherwise it is low.
- R12: While `rst_n` is low, `rdata`, `host_irq` and `card_rst` are 0 and the option, status and pin registers are zero.
- R13: `rdata` updates only on the edge that samples `rd_en` high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Attribute-space byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rom_addr | output | ADDR_W | Address to the card-information ROM |
| rom_data | input | 8 | Byte returned by the ROM |
| ctl_irq_off | input | 1 | Device-control interrupt-disable bit |
| ctl_soft_rst | input | 1 | Device-control soft-reset bit |
| ide_irq | input | 1 | Interrupt line of the inner disk controller |
| host_irq | output | 1 | Registered interrupt request to the host |
| card_rst | output | 1 | One-cycle reset pulse to the rest of the card |

## Verification
The bench builds the bank with an 8-bit address, the base at 0x40 and a 0x30-byte ROM. With that setup every address can be swept in a few hundred cycles, and the ROM window, the gap past the ROM end and every undefined register offset are all reached in one pass. The byte-wide data lets the bench write all 256 values to the option and status registers and compare each read-back against the mask arithmetic. The three interrupt-control inputs are small enough to walk through all eight combinations.

// File: rtl/pccfg_pkg.sv
package pccfg_pkg;
  typedef logic [7:0] byte_t;

  localparam int OFF_OPT  = 0;
  localparam int OFF_STAT = 2;
  localparam int OFF_PIN  = 4;
  localparam int OFF_SOCK = 6;

  localparam byte_t OPT_KEEP   = 8'hCF;
  localparam int    OPT_SRST_B = 7;

  localparam byte_t STAT_HOLD  = 8'h82;
  localparam byte_t STAT_LOAD  = 8'h74;
  localparam int    STAT_IRQ_B = 1;
  localparam int    STAT_PD_B  = 2;

  localparam int    PIN_RDY_B  = 5;
  localparam int    PIN_MRDY_B = 1;
  localparam byte_t PIN_FIXED  = 8'h0C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROM,
    SEL_OPT,
    SEL_STAT,
    SEL_PIN,
    SEL_SOCK
  } sel_e;
endpackage

// File: rtl/pccfg_decode.sv
module pccfg_decode
  import pccfg_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int ATTR_BASE = 512,
  parameter int ROM_LEN   = 330
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  localparam int ROM_END = (ROM_LEN < ATTR_BASE) ? ROM_LEN : ATTR_BASE;
  localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(ATTR_BASE);
  localparam logic [ADDR_W:0] REND_X = (ADDR_W+1)'(ROM_END);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(ATTR_BASE);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off = addr - BASE_A;
    sel = SEL_NONE;
    if ({1'b0, addr} < BASE_X) begin
      if ({1'b0, addr} < REND_X) sel = SEL_ROM;
    end else begin
      if (off == ADDR_W'(OFF_OPT))       sel = SEL_OPT;
      else if (off == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
      else if (off == ADDR_W'(OFF_PIN))  sel = SEL_PIN;
      else if (off == ADDR_W'(OFF_SOCK)) sel = SEL_SOCK;
    end
  end
endmodule

// File: rtl/pccfg_regs.sv
module pccfg_regs
  import pccfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  sel_e  sel,
  input  byte_t wdata,
  input  logic  irq_line,
  output byte_t opt_q,
  output byte_t stat_q,
  output byte_t pin_q,
  output byte_t stat_n,
  output logic  soft_rst,
  output logic  rst_pulse_q
);
  byte_t opt_n, pin_n;

  always_comb begin
    opt_n    = opt_q;
    stat_n   = stat_q;
    pin_n    = pin_q;
    soft_rst = 1'b0;
    if (wr_en) begin
      unique case (sel)
        SEL_OPT: begin
          opt_n    = wdata & OPT_KEEP;
          soft_rst = wdata[OPT_SRST_B];
        end
        SEL_STAT: begin
          if (stat_q[STAT_PD_B] != wdata[STAT_PD_B]) pin_n[PIN_RDY_B] = 1'b1;
          stat_n = (stat_q & STAT_HOLD) | (wdata & STAT_LOAD);
        end
        SEL_PIN: begin
          pin_n = '0;
          pin_n[PIN_RDY_B]  = pin_q[PIN_RDY_B];
          pin_n[PIN_MRDY_B] = wdata[PIN_MRDY_B];
        end
        default: ;
      endcase
    end
    stat_n[STAT_IRQ_B] = ~irq_line;
    if (soft_rst) begin
      opt_n  = '0;
      stat_n = '0;
      pin_n  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_q       <= '0;
      stat_q      <= '0;
      pin_q       <= '0;
      rst_pulse_q <= 1'b0;
    end else begin
      opt_q       <= opt_n;
      stat_q      <= stat_n;
      pin_q       <= pin_n;
      rst_pulse_q <= soft_rst;
    end
  end
endmodule

// File: rtl/pccfg_irq.sv
module pccfg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_irq_n,
  input  logic srst_n,
  input  logic irq_off,
  input  logic ctl_srst,
  output logic irq_q
);
  logic irq_d;

  always_comb irq_d = !stat_irq_n && !irq_off && !ctl_srst && !srst_n;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/pccfg_bank.sv
module pccfg_bank
  import pccfg_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int ATTR_BASE = 512,
  parameter int ROM_LEN   = 330
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  input  logic              ctl_irq_off,
  input  logic              ctl_soft_rst,
  input  logic              ide_irq,
  output logic              host_irq,
  output logic              card_rst
);
  sel_e  sel;
  byte_t opt_q, stat_q, pin_q, stat_n;
  logic  soft_rst;
  byte_t rd_mux;
  byte_t rdata_q;

  pccfg_decode #(
    .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE), .ROM_LEN(ROM_LEN)
  ) u_dec (
    .addr(addr), .sel(sel)
  );

  pccfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .irq_line(ide_irq), .opt_q(opt_q), .stat_q(stat_q), .pin_q(pin_q),
    .stat_n(stat_n), .soft_rst(soft_rst), .rst_pulse_q(card_rst)
  );

  pccfg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .stat_irq_n(stat_n[STAT_IRQ_B]),
    .srst_n(soft_rst), .irq_off(ctl_irq_off), .ctl_srst(ctl_soft_rst),
    .irq_q(host_irq)
  );

  always_comb begin
    unique case (sel)
      SEL_ROM:  rd_mux = rom_data;
      SEL_OPT:  rd_mux = opt_q;
      SEL_STAT: rd_mux = ctl_irq_off ? (stat_q & ~(byte_t'(1) << STAT_IRQ_B)) : stat_q;
      SEL_PIN:  rd_mux = (pin_q & (byte_t'(1) << PIN_RDY_B)) | PIN_FIXED;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata    = rdata_q;
  assign rom_addr = addr;
endmodule

// File: rtl/pccfg_bank_chk.sv
module pccfg_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       ide_irq,
  input logic       ctl_irq_off,
  input logic       ctl_soft_rst,
  input logic       host_irq,
  input logic       card_rst,
  input logic       pin_rdy
);
  assert_rst_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> !card_rst);

  assert_rst_quiet_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> !host_irq);

  assert_irq_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(ide_irq));

  assert_irq_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_irq_off || ctl_soft_rst) |-> !host_irq);

  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));

  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_rdy) && !card_rst) |-> pin_rdy);
endmodule

bind pccfg_bank pccfg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rdata(rdata), .ide_irq(ide_irq),
  .ctl_irq_off(ctl_irq_off), .ctl_soft_rst(ctl_soft_rst),
  .host_irq(host_irq), .card_rst(card_rst), .pin_rdy(pin_q[5])
);

// File: tb/tb_pccfg_bank.sv
module tb_pccfg_bank;
  localparam int AW   = 8;
  localparam int BASE = 64;
  localparam int RLEN = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [AW-1:0] rom_addr;
  logic [7:0] rom_data;
  logic ctl_irq_off = 1'b0, ctl_soft_rst = 1'b0, ide_irq = 1'b0;
  logic host_irq, card_rst;

  int checks = 0;
  int errors = 0;

  logic [7:0] opt_m, stat_m, pin_m;

  always #2.5 clk = ~clk;

  assign rom_data = rom_addr ^ 8'hA5;

  pccfg_bank #(.ADDR_W(AW), .ATTR_BASE(BASE), .ROM_LEN(RLEN)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rom_addr(rom_addr), .rom_data(rom_data),
    .ctl_irq_off(ctl_irq_off), .ctl_soft_rst(ctl_soft_rst), .ide_irq(ide_irq),
    .host_irq(host_irq), .card_rst(card_rst)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input int a);
    logic [7:0] s;
    if (a < BASE) return (a < RLEN) ? (8'(a) ^ 8'hA5) : 8'h00;
    case (a - BASE)
      0: return opt_m;
      2: begin
        s = (stat_m & 8'hFD) | (ide_irq ? 8'h00 : 8'h02);
        return ctl_irq_off ? (s & 8'hFD) : s;
      end
      4: return (pin_m & 8'h20) | 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    if (a < BASE) return (a < RLEN) ? "R1" : "R2";
    case (a - BASE)
      0: return "R3";
      2: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wr(input int a, input logic [7:0] v, output logic pulse);
    @(negedge clk);
    addr = AW'(a); wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    pulse = card_rst;
    @(negedge clk);
  endtask

  task automatic wr_model(input int a, input logic [7:0] v);
    if (a >= BASE) begin
      case (a - BASE)
        0: if (v[7]) begin opt_m = 0; stat_m = 0; pin_m = 0; end
           else opt_m = v & 8'hCF;
        2: begin
          if ((stat_m[2] ^ v[2]) != 1'b0) pin_m[5] = 1'b1;
          stat_m = (stat_m & 8'h82) | (v & 8'h74);
        end
        4: pin_m = (pin_m & 8'h20) | (v & 8'h02);
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic p;
    opt_m = 0; stat_m = 0; pin_m = 0;

    // R12: state while reset is held
    repeat (3) @(negedge clk);
    chk("R12 rdata", rdata, 8'h00);
    chk("R12 host_irq", {7'b0, host_irq}, 8'h00);
    chk("R12 card_rst", {7'b0, card_rst}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 irq idle after reset", {7'b0, host_irq}, 8'h00);

    // R1 R2 R9: sweep every address after reset
    for (int a = 0; a < 256; a++) begin
      rd(a, d);
      chk(tag_of(a), d, exp_read(a));
    end

    // R3 R4: all option values
    for (int v = 0; v < 256; v++) begin
      wr(BASE, 8'(v), p);
      wr_model(BASE, 8'(v));
      chk("R4 card_rst pulse", {7'b0, p}, {7'b0, v[7]});
      rd(BASE, d);
      chk(v[7] ? "R4 option cleared" : "R3 option mask", d, opt_m);
    end
    rd(BASE + 2, d);
    chk("R4 status cleared", d, exp_read(BASE + 2));
    rd(BASE + 4, d);
    chk("R4 pin cleared", d, 8'h0C);

    // R6: equal power-down bit leaves card-ready clear
    wr(BASE + 2, 8'h00, p); wr_model(BASE + 2, 8'h00);
    rd(BASE + 4, d);
    chk("R6 no toggle", d, 8'h0C);

    // R5 R6: all status values
    for (int v = 0; v < 256; v++) begin
      wr(BASE + 2, 8'(v), p);
      wr_model(BASE + 2, 8'(v));
      rd(BASE + 2, d);
      chk("R5 status keep/load", d, exp_read(BASE + 2));
      rd(BASE + 4, d);
      chk("R6 card ready", d, exp_read(BASE + 4));
    end

    // R8: pin writes never clear card-ready
    wr(BASE + 4, 8'h00, p); wr_model(BASE + 4, 8'h00);
    rd(BASE + 4, d);
    chk("R8 pin write keeps ready", d, 8'h2C);

    // R9: writes to ROM area and undefined offsets change nothing
    wr(BASE, 8'h41, p); wr_model(BASE, 8'h41);
    wr(BASE + 2, 8'h30, p); wr_model(BASE + 2, 8'h30);
    for (int a = 0; a < 256; a++) begin
      if (!(a >= BASE && (a - BASE == 0 || a - BASE == 2 || a - BASE == 4))) begin
        wr(a, 8'hFF, p);
      end
    end
    rd(BASE, d);     chk("R9 option untouched", d, opt_m);
    rd(BASE + 2, d); chk("R9 status untouched", d, exp_read(BASE + 2));
    rd(BASE + 4, d); chk("R9 pin untouched", d, exp_read(BASE + 4));
    rd(BASE + 6, d); chk("R9 socket reads zero", d, 8'h00);

    // R7 R10 R11: all interrupt input combinations
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      ide_irq = c[0]; ctl_irq_off = c[1]; ctl_soft_rst = c[2];
      @(negedge clk);
      chk("R11 host_irq", {7'b0, host_irq}, {7'b0, c[0] & ~c[1] & ~c[2]});
      rd(BASE + 2, d);
      chk(c[1] ? "R7 status masked" : "R10 status irq bit", d, exp_read(BASE + 2));
    end

    // R4 R11: soft-reset write forces irq low for one cycle
    @(negedge clk);
    ide_irq = 1'b1; ctl_irq_off = 1'b0; ctl_soft_rst = 1'b0;
    @(negedge clk);
    chk("R11 irq raised", {7'b0, host_irq}, 8'h01);
    addr = AW'(BASE); wdata = 8'h80; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 irq low on soft reset", {7'b0, host_irq}, 8'h00);
    chk("R4 pulse high", {7'b0, card_rst}, 8'h01);
    wr_model(BASE, 8'h80);
    @(negedge clk);
    chk("R4 pulse one cycle", {7'b0, card_rst}, 8'h00);
    chk("R11 irq back", {7'b0, host_irq}, 8'h01);

    // R13: rdata holds without a read strobe
    rd(BASE + 4, d);
    @(negedge clk); ide_irq = 1'b0; addr = AW'(5);
    repeat (3) @(negedge clk);
    chk("R13 rdata held", rdata, 8'h0C);

    finish_run();
  end
endmodule